// File: doc/BRIEF.md
# Interruption Entry Sequencer

When a processor core takes an interruption with vector number N, this block does the architectural save and redirect over several clock cycles. On a request it takes a snapshot of the processor status word (PSW), the front and back instruction space and offset queues, seven selected general registers, the vector base address and a default-wide configuration flag. It then steps through a fixed order. First it saves the PSW and builds the new one. Next it captures the interruption space and offset queues. Under some conditions it fetches the faulting instruction word. It then copies the general registers into shadow registers, and last it computes the handler address.

The instruction word is fetched through a small request/response port. The request uses a valid/ready handshake. The response carries the data and a translation-fault flag. Address translation is done by whatever answers this port. The block raises `busy` while it runs. When every saved register and every new value is in place, it gives a one-cycle `done` pulse.

PSW bit positions used throughout: bit 0 is Q (state-collection enable), bit 1 is C (code translation), bit 2 is W (wide), bit 3 is M (machine-check mask). Vector 1 is the high-priority machine check. Vector 31 is transfer-of-control. Vectors 12 to 28 inclusive form the data-fault and trap group.

Top module: `intr_entry_seq`

## Requirements
- R1: When the block is idle and `req_valid` is 1 at a rising edge, it accepts the request, raises `busy` on that edge and snapshots every input. While `busy` is 1, new requests are ignored and input changes have no effect. When it is done, `ipsw` equals the PSW that was sampled.
- R2: `new_psw` is all zeros except two bits. Bit 2 (W) equals the default-wide flag. Bit 3 (M) is 1 only when the vector is 1.
- R3: If the old PSW bit 1 (C) is 0, `iiasq_f` and `iiasq_b` are 0. If C is 1, they hold the top 32 bits of the global address. That value is the space itself when old W is 0, and the space OR offset[63:32] when old W is 1.
- R4: If the old PSW bit 2 (W) is 1, `iiaoq_f` and `iiaoq_b` hold the full 64-bit front and back offsets. Otherwise they hold the offsets with bits 63:32 cleared.
- R5: Only when the old PSW bit 0 (Q) is 1, shadow entries 0 to 6 take the general-register inputs in slots 0 to 6 (registers 1, 8, 9, 16, 17, 24, 25). When Q is 0, the shadow entries keep their values.
- R6: Only when Q is 1 and the vector is in 12..28, the block makes exactly one read at the front offset with bits 1:0 cleared. `iir` then gets the returned word, or 0 if the response signals a translation fault. In all other cases no read is made and `iir` keeps its value.
- R7: For vectors other than 31, `new_iaoq_f` is the vector base plus 32×N. In every case `new_iaoq_b` is `new_iaoq_f` + 4, and both new space queues are 0.
- R8: For vector 31, `new_iaoq_f` is the fixed firmware start address (0xF000_0000 by default). `gr_wr_en` pulses together with `done`, with `gr24_wdata` equal to the zero-extended saved back space and `gr25_wdata` equal to the saved back offset. For other vectors, `gr_wr_en` stays 0.
- R9: `done` is high for exactly one cycle. It rises on the same edge that `busy` falls, and all outputs are final when it is high.
- R10: `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is seen. The block then waits in a dedicated state until `rsp_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Interruption accepted; start the sequence |
| req_vec | input | 5 | Vector number N |
| psw_in | input | 32 | Current PSW |
| iasq_f_in | input | 32 | Front space queue |
| iasq_b_in | input | 32 | Back space queue |
| iaoq_f_in | input | 64 | Front offset queue |
| iaoq_b_in | input | 64 | Back offset queue |
| gr_in | input | 448 | Seven general registers, slot k at bits 64k+63:64k |
| iva_in | input | 64 | Interruption vector base address |
| dflt_wide_in | input | 1 | Default-wide configuration flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ipsw | output | 32 | Saved PSW |
| iiasq_f | output | 32 | Saved front space |
| iiasq_b | output | 32 | Saved back space |
| iiaoq_f | output | 64 | Saved front offset |
| iiaoq_b | output | 64 | Saved back offset |
| iir | output | 32 | Interruption instruction word |
| shadow_out | output | 448 | Shadow registers, entry k at bits 64k+63:64k |
| new_psw | output | 32 | PSW for the handler |
| new_iasq_f | output | 32 | New front space (zero) |
| new_iasq_b | output | 32 | New back space (zero) |
| new_iaoq_f | output | 64 | Handler front offset |
| new_iaoq_b | output | 64 | Handler back offset |
| gr_wr_en | output | 1 | Write gr24/gr25 (transfer-of-control) |
| gr24_wdata | output | 64 | Value for general register 24 |
| gr25_wdata | output | 64 | Value for general register 25 |
| rd_valid | output | 1 | Instruction-word read request |
| rd_addr | output | 64 | Word-aligned read address |
| rd_ready | input | 1 | Read request taken |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | 32 | Read data |
| rsp_fault | input | 1 | Translation failed for the read |

## Verification
The assertions assume that the responder raises `rsp_valid` only once, and only after it has accepted a read with `rd_ready`. They also assume that `rd_ready` is only given while `rd_valid` is high. The bench responder works as a small state machine that takes one address, inserts random delays before ready and before the response, and never answers twice. The bench also pulses `req_valid` and changes every input while the sequence runs, so it exercises the rule that such activity is ignored.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    // PSW bit positions
    localparam int PSW_Q_BIT = 0;
    localparam int PSW_C_BIT = 1;
    localparam int PSW_W_BIT = 2;
    localparam int PSW_M_BIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PSW    = 3'd1,
        ST_QUEUE  = 3'd2,
        ST_FETCH  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_SHADOW = 3'd5,
        ST_REDIR  = 3'd6
    } ient_state_e;

endpackage

// File: rtl/intr_entry_queue_calc.sv
module intr_entry_queue_calc #(
    parameter int OFF_W    = 64,
    parameter int SPC_W    = 32,
    parameter int NARROW_W = 32
) (
    input  logic             xlate_on,
    input  logic             wide_on,
    input  logic [SPC_W-1:0] spc_f,
    input  logic [SPC_W-1:0] spc_b,
    input  logic [OFF_W-1:0] off_f,
    input  logic [OFF_W-1:0] off_b,
    output logic [SPC_W-1:0] sq_f,
    output logic [SPC_W-1:0] sq_b,
    output logic [OFF_W-1:0] oq_f,
    output logic [OFF_W-1:0] oq_b
);
    localparam int HI_SHIFT = OFF_W - SPC_W;

    logic [SPC_W-1:0] spc_a [2];
    logic [OFF_W-1:0] off_a [2];
    logic [SPC_W-1:0] sq_a  [2];
    logic [OFF_W-1:0] oq_a  [2];

    assign spc_a[0] = spc_f;
    assign spc_a[1] = spc_b;
    assign off_a[0] = off_f;
    assign off_a[1] = off_b;

    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic [SPC_W-1:0] gva_hi;
        always_comb begin
            gva_hi = wide_on ? (spc_a[lane] | SPC_W'(off_a[lane] >> HI_SHIFT))
                             : spc_a[lane];
            sq_a[lane] = xlate_on ? gva_hi : '0;
            oq_a[lane] = wide_on ? off_a[lane]
                                 : OFF_W'(off_a[lane][NARROW_W-1:0]);
        end
    end

    assign sq_f = sq_a[0];
    assign sq_b = sq_a[1];
    assign oq_f = oq_a[0];
    assign oq_b = oq_a[1];
endmodule

// File: rtl/intr_entry_vector_calc.sv
module intr_entry_vector_calc #(
    parameter int               OFF_W        = 64,
    parameter int               VEC_W        = 5,
    parameter int               SPACING_LOG2 = 5,
    parameter int               TOC_VEC      = 31,
    parameter logic [OFF_W-1:0] FW_START     = 64'hF000_0000
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [OFF_W-1:0] base,
    output logic             is_toc,
    output logic [OFF_W-1:0] tgt_f,
    output logic [OFF_W-1:0] tgt_b
);
    always_comb begin
        is_toc = (vec == VEC_W'(TOC_VEC));
        tgt_f  = is_toc ? FW_START : base + (OFF_W'(vec) << SPACING_LOG2);
        tgt_b  = tgt_f + OFF_W'(4);
    end
endmodule

// File: rtl/intr_entry_shadow_bank.sv
module intr_entry_shadow_bank #(
    parameter int N_ENT = 7,
    parameter int ENT_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [N_ENT*ENT_W-1:0] din,
    output logic [N_ENT*ENT_W-1:0] dout
);
    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic [ENT_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = wr_en ? din[k*ENT_W +: ENT_W] : ent_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign dout[k*ENT_W +: ENT_W] = ent_q;
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter int               OFF_W        = 64,
    parameter int               SPC_W        = 32,
    parameter int               NARROW_W     = 32,
    parameter int               GR_W         = 64,
    parameter int               PSW_W        = 32,
    parameter int               INSN_W       = 32,
    parameter int               VEC_W        = 5,
    parameter int               N_SHADOW     = 7,
    parameter int               SPACING_LOG2 = 5,
    parameter int               HPMC_VEC     = 1,
    parameter int               TOC_VEC      = 31,
    parameter int               GRP_LO       = 12,
    parameter int               GRP_HI       = 28,
    parameter logic [OFF_W-1:0] FW_START     = 64'hF000_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VEC_W-1:0]         req_vec,
    input  logic [PSW_W-1:0]         psw_in,
    input  logic [SPC_W-1:0]         iasq_f_in,
    input  logic [SPC_W-1:0]         iasq_b_in,
    input  logic [OFF_W-1:0]         iaoq_f_in,
    input  logic [OFF_W-1:0]         iaoq_b_in,
    input  logic [N_SHADOW*GR_W-1:0] gr_in,
    input  logic [OFF_W-1:0]         iva_in,
    input  logic                     dflt_wide_in,
    output logic                     busy,
    output logic                     done,
    output logic [PSW_W-1:0]         ipsw,
    output logic [SPC_W-1:0]         iiasq_f,
    output logic [SPC_W-1:0]         iiasq_b,
    output logic [OFF_W-1:0]         iiaoq_f,
    output logic [OFF_W-1:0]         iiaoq_b,
    output logic [INSN_W-1:0]        iir,
    output logic [N_SHADOW*GR_W-1:0] shadow_out,
    output logic [PSW_W-1:0]         new_psw,
    output logic [SPC_W-1:0]         new_iasq_f,
    output logic [SPC_W-1:0]         new_iasq_b,
    output logic [OFF_W-1:0]         new_iaoq_f,
    output logic [OFF_W-1:0]         new_iaoq_b,
    output logic                     gr_wr_en,
    output logic [GR_W-1:0]          gr24_wdata,
    output logic [GR_W-1:0]          gr25_wdata,
    output logic                     rd_valid,
    output logic [OFF_W-1:0]         rd_addr,
    input  logic                     rd_ready,
    input  logic                     rsp_valid,
    input  logic [INSN_W-1:0]        rsp_data,
    input  logic                     rsp_fault
);
    localparam int GR_FLAT = N_SHADOW * GR_W;

    typedef struct packed {
        ient_state_e        st;
        logic [VEC_W-1:0]   vec;
        logic [PSW_W-1:0]   psw;
        logic [SPC_W-1:0]   spc_f;
        logic [SPC_W-1:0]   spc_b;
        logic [OFF_W-1:0]   off_f;
        logic [OFF_W-1:0]   off_b;
        logic [OFF_W-1:0]   base;
        logic               wide;
        logic [GR_FLAT-1:0] gr;
        logic [PSW_W-1:0]   ipsw;
        logic [SPC_W-1:0]   iiasq_f;
        logic [SPC_W-1:0]   iiasq_b;
        logic [OFF_W-1:0]   iiaoq_f;
        logic [OFF_W-1:0]   iiaoq_b;
        logic [INSN_W-1:0]  iir;
        logic [PSW_W-1:0]   npsw;
        logic [OFF_W-1:0]   niaoq_f;
        logic [OFF_W-1:0]   niaoq_b;
        logic               gr_we;
        logic [GR_W-1:0]    gr24;
        logic [GR_W-1:0]    gr25;
        logic               done;
    } seq_s;

    seq_s s_d, s_q;

    logic             old_q, old_c, old_w, in_group;
    logic             shadow_we;
    logic [SPC_W-1:0] qc_sq_f, qc_sq_b;
    logic [OFF_W-1:0] qc_oq_f, qc_oq_b;
    logic             vc_toc;
    logic [OFF_W-1:0] vc_tgt_f, vc_tgt_b;

    assign old_q    = s_q.psw[PSW_Q_BIT];
    assign old_c    = s_q.psw[PSW_C_BIT];
    assign old_w    = s_q.psw[PSW_W_BIT];
    assign in_group = (s_q.vec >= VEC_W'(GRP_LO)) && (s_q.vec <= VEC_W'(GRP_HI));

    intr_entry_queue_calc #(
        .OFF_W(OFF_W), .SPC_W(SPC_W), .NARROW_W(NARROW_W)
    ) queue_i (
        .xlate_on (old_c),
        .wide_on  (old_w),
        .spc_f    (s_q.spc_f),
        .spc_b    (s_q.spc_b),
        .off_f    (s_q.off_f),
        .off_b    (s_q.off_b),
        .sq_f     (qc_sq_f),
        .sq_b     (qc_sq_b),
        .oq_f     (qc_oq_f),
        .oq_b     (qc_oq_b)
    );

    intr_entry_vector_calc #(
        .OFF_W(OFF_W), .VEC_W(VEC_W), .SPACING_LOG2(SPACING_LOG2),
        .TOC_VEC(TOC_VEC), .FW_START(FW_START)
    ) vector_i (
        .vec    (s_q.vec),
        .base   (s_q.base),
        .is_toc (vc_toc),
        .tgt_f  (vc_tgt_f),
        .tgt_b  (vc_tgt_b)
    );

    intr_entry_shadow_bank #(
        .N_ENT(N_SHADOW), .ENT_W(GR_W)
    ) shadow_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (shadow_we),
        .din   (s_q.gr),
        .dout  (shadow_out)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.gr_we = 1'b0;
        shadow_we = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.vec   = req_vec;
                    s_d.psw   = psw_in;
                    s_d.spc_f = iasq_f_in;
                    s_d.spc_b = iasq_b_in;
                    s_d.off_f = iaoq_f_in;
                    s_d.off_b = iaoq_b_in;
                    s_d.base  = iva_in;
                    s_d.wide  = dflt_wide_in;
                    s_d.gr    = gr_in;
                    s_d.st    = ST_PSW;
                end
            end
            ST_PSW: begin
                s_d.ipsw                = s_q.psw;
                s_d.npsw                = '0;
                s_d.npsw[PSW_W_BIT]     = s_q.wide;
                s_d.npsw[PSW_M_BIT]     = (s_q.vec == VEC_W'(HPMC_VEC));
                s_d.st                  = ST_QUEUE;
            end
            ST_QUEUE: begin
                s_d.iiasq_f = qc_sq_f;
                s_d.iiasq_b = qc_sq_b;
                s_d.iiaoq_f = qc_oq_f;
                s_d.iiaoq_b = qc_oq_b;
                s_d.st      = (old_q && in_group) ? ST_FETCH : ST_SHADOW;
            end
            ST_FETCH: begin
                if (rd_ready) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    s_d.iir = rsp_fault ? '0 : rsp_data;
                    s_d.st  = ST_SHADOW;
                end
            end
            ST_SHADOW: begin
                shadow_we = old_q;
                s_d.st    = ST_REDIR;
            end
            ST_REDIR: begin
                s_d.niaoq_f = vc_tgt_f;
                s_d.niaoq_b = vc_tgt_b;
                if (vc_toc) begin
                    s_d.gr_we = 1'b1;
                    s_d.gr24  = GR_W'(s_q.iiasq_b);
                    s_d.gr25  = GR_W'(s_q.iiaoq_b);
                end
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;
    assign ipsw       = s_q.ipsw;
    assign iiasq_f    = s_q.iiasq_f;
    assign iiasq_b    = s_q.iiasq_b;
    assign iiaoq_f    = s_q.iiaoq_f;
    assign iiaoq_b    = s_q.iiaoq_b;
    assign iir        = s_q.iir;
    assign new_psw    = s_q.npsw;
    assign new_iasq_f = '0;
    assign new_iasq_b = '0;
    assign new_iaoq_f = s_q.niaoq_f;
    assign new_iaoq_b = s_q.niaoq_b;
    assign gr_wr_en   = s_q.gr_we;
    assign gr24_wdata = s_q.gr24;
    assign gr25_wdata = s_q.gr25;
    assign rd_valid   = (s_q.st == ST_FETCH);
    assign rd_addr    = {s_q.off_f[OFF_W-1:2], 2'b00};
endmodule

// File: rtl/intr_entry_checker.sv
module intr_entry_checker
    import intr_entry_pkg::*;
#(
    parameter int OFF_W = 64,
    parameter int PSW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             done,
    input logic [PSW_W-1:0] new_psw,
    input logic [OFF_W-1:0] new_iaoq_f,
    input logic [OFF_W-1:0] new_iaoq_b,
    input logic             gr_wr_en,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [OFF_W-1:0] rd_addr
);
    localparam logic [PSW_W-1:0] NEW_PSW_MASK =
        (PSW_W'(1) << PSW_W_BIT) | (PSW_W'(1) << PSW_M_BIT);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_psw_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((new_psw & ~NEW_PSW_MASK) == '0));

    p_addr_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr[1:0] == 2'b00));

    p_back_follows_front_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_iaoq_b == new_iaoq_f + OFF_W'(4)));

    p_grwr_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gr_wr_en |-> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

bind intr_entry_seq intr_entry_checker #(
    .OFF_W(OFF_W), .PSW_W(PSW_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .new_psw    (new_psw),
    .new_iaoq_f (new_iaoq_f),
    .new_iaoq_b (new_iaoq_b),
    .gr_wr_en   (gr_wr_en),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr)
);

// File: tb/intr_entry_seq_tb_top.sv
`timescale 1ns/1ps
module intr_entry_seq_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [4:0]   req_vec = '0;
    logic [31:0]  psw_in = '0, iasq_f_in = '0, iasq_b_in = '0;
    logic [63:0]  iaoq_f_in = '0, iaoq_b_in = '0, iva_in = '0;
    logic [447:0] gr_in = '0;
    logic         dflt_wide_in = 1'b0;
    logic         busy, done, gr_wr_en, rd_valid;
    logic [31:0]  ipsw, iiasq_f, iiasq_b, iir, new_psw, new_iasq_f, new_iasq_b;
    logic [63:0]  iiaoq_f, iiaoq_b, new_iaoq_f, new_iaoq_b, gr24_wdata, gr25_wdata, rd_addr;
    logic [447:0] shadow_out;
    logic         rd_ready = 1'b0, rsp_valid = 1'b0, rsp_fault = 1'b0;
    logic [31:0]  rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [63:0] last_addr = '0;
    logic [447:0] exp_shadow = '0;
    logic [31:0]  exp_iir = '0;

    always #4 clk = ~clk;

    intr_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
        .psw_in(psw_in), .iasq_f_in(iasq_f_in), .iasq_b_in(iasq_b_in),
        .iaoq_f_in(iaoq_f_in), .iaoq_b_in(iaoq_b_in), .gr_in(gr_in),
        .iva_in(iva_in), .dflt_wide_in(dflt_wide_in), .busy(busy), .done(done),
        .ipsw(ipsw), .iiasq_f(iiasq_f), .iiasq_b(iiasq_b), .iiaoq_f(iiaoq_f),
        .iiaoq_b(iiaoq_b), .iir(iir), .shadow_out(shadow_out), .new_psw(new_psw),
        .new_iasq_f(new_iasq_f), .new_iasq_b(new_iasq_b), .new_iaoq_f(new_iaoq_f),
        .new_iaoq_b(new_iaoq_b), .gr_wr_en(gr_wr_en), .gr24_wdata(gr24_wdata),
        .gr25_wdata(gr25_wdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_fault(rsp_fault)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ a[63:32];
    endfunction

    function automatic logic [31:0] exp_space(input logic [31:0] p, input logic [31:0] s,
                                              input logic [63:0] o);
        if (!p[1]) return 32'h0;
        return p[2] ? (s | o[63:32]) : s;
    endfunction

    function automatic logic [63:0] exp_off(input logic [31:0] p, input logic [63:0] o);
        return p[2] ? o : {32'h0, o[31:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Responder: one read at a time, random delays before ready and response
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                repeat ($urandom % 3) @(negedge clk);
                rd_ready = 1'b1;
                last_addr = rd_addr;
                @(negedge clk);
                rd_ready = 1'b0;
                rd_count++;
                repeat ($urandom % 4) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = mem_word(last_addr);
                rsp_fault = last_addr[3];
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_case(input logic [4:0] vec, input logic [31:0] p,
                            input logic [31:0] sf, input logic [31:0] sb,
                            input logic [63:0] of, input logic [63:0] ob,
                            input logic [63:0] base, input logic wide,
                            input logic [447:0] gr, input bit poke);
        int n;
        int rd0;
        bit fetch;
        logic [63:0] ef, ea;
        @(negedge clk);
        req_vec = vec; psw_in = p; iasq_f_in = sf; iasq_b_in = sb;
        iaoq_f_in = of; iaoq_b_in = ob; iva_in = base; dflt_wide_in = wide; gr_in = gr;
        req_valid = 1'b1;
        rd0 = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 200) begin
            if (poke && n == 1) begin
                req_valid = 1'b1;
                req_vec = 5'($urandom); psw_in = $urandom; iasq_f_in = $urandom;
                iasq_b_in = $urandom; iaoq_f_in = {$urandom, $urandom};
                iaoq_b_in = {$urandom, $urandom}; iva_in = {$urandom, $urandom};
                dflt_wide_in = ~wide; gr_in = ~gr;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R9", "done seen", 64'(done), 64'd1);
        fetch = p[0] && (vec >= 5'd12) && (vec <= 5'd28);
        if (fetch) exp_iir = last_addr[3] ? 32'h0 : mem_word({of[63:2], 2'b00});
        if (p[0]) exp_shadow = gr;
        chk(ipsw == p, "R1", "ipsw", 64'(ipsw), 64'(p));
        chk(new_psw == ((32'(wide) << 2) | (32'(vec == 5'd1) << 3)), "R2", "new_psw",
            64'(new_psw), 64'((32'(wide) << 2) | (32'(vec == 5'd1) << 3)));
        chk(iiasq_f == exp_space(p, sf, of), "R3", "iiasq_f", 64'(iiasq_f), 64'(exp_space(p, sf, of)));
        chk(iiasq_b == exp_space(p, sb, ob), "R3", "iiasq_b", 64'(iiasq_b), 64'(exp_space(p, sb, ob)));
        chk(iiaoq_f == exp_off(p, of), "R4", "iiaoq_f", iiaoq_f, exp_off(p, of));
        chk(iiaoq_b == exp_off(p, ob), "R4", "iiaoq_b", iiaoq_b, exp_off(p, ob));
        for (int k = 0; k < 7; k++)
            chk(shadow_out[k*64 +: 64] == exp_shadow[k*64 +: 64], "R5", "shadow entry",
                shadow_out[k*64 +: 64], exp_shadow[k*64 +: 64]);
        chk((rd_count - rd0) == (fetch ? 1 : 0), "R6", "read count",
            64'(rd_count - rd0), fetch ? 64'd1 : 64'd0);
        if (fetch) begin
            ea = {of[63:2], 2'b00};
            chk(last_addr == ea, "R6", "read address", last_addr, ea);
        end
        chk(iir == exp_iir, "R6", "iir", 64'(iir), 64'(exp_iir));
        ef = (vec == 5'd31) ? 64'hF000_0000 : base + (64'(vec) << 5);
        chk(new_iaoq_f == ef, vec == 5'd31 ? "R8" : "R7", "new_iaoq_f", new_iaoq_f, ef);
        chk(new_iaoq_b == ef + 64'd4, "R7", "new_iaoq_b", new_iaoq_b, ef + 64'd4);
        chk(new_iasq_f == 32'h0 && new_iasq_b == 32'h0, "R7", "new space zero",
            {new_iasq_f, new_iasq_b}, 64'h0);
        chk(gr_wr_en == (vec == 5'd31), "R8", "gr_wr_en", 64'(gr_wr_en), 64'(vec == 5'd31));
        if (vec == 5'd31) begin
            chk(gr24_wdata == 64'(exp_space(p, sb, ob)), "R8", "gr24_wdata",
                gr24_wdata, 64'(exp_space(p, sb, ob)));
            chk(gr25_wdata == exp_off(p, ob), "R8", "gr25_wdata", gr25_wdata, exp_off(p, ob));
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done single cycle, idle",
            {62'h0, done, busy}, 64'h0);
    endtask

    function automatic logic [447:0] rand_gr();
        logic [447:0] g;
        for (int k = 0; k < 14; k++) g[k*32 +: 32] = $urandom;
        return g;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R9", "reset outputs",
            {61'h0, busy, done, rd_valid}, 64'h0);
        chk(ipsw == 32'h0 && iir == 32'h0, "R1", "reset saved regs", {ipsw, iir}, 64'h0);
        rst_n = 1'b1;
        // directed: fetch group, Q C W set, no fault (bit3 of address clear)
        run_case(5'd14, 32'h0000_0007, 32'h1111_0000, 32'h2222_0000,
                 64'h0000_0044_0000_1004, 64'h0000_0044_0000_1010,
                 64'h0000_0000_0010_0000, 1'b1, rand_gr(), 1'b0);
        // directed: fault on translation (address bit 3 set)
        run_case(5'd20, 32'h0000_0001, 32'h3, 32'h4, 64'hFFFF_0000_0000_200B,
                 64'h0, 64'h8000, 1'b0, rand_gr(), 1'b1);
        // directed: Q clear, group vector -> no read, iir/shadow hold, narrow truncation
        run_case(5'd12, 32'h0000_0002, 32'hABCD_0001, 32'h5, 64'hDEAD_BEEF_1234_5678,
                 64'hCAFE_0000_0000_0010, 64'h4000, 1'b0, rand_gr(), 1'b1);
        // directed: machine check vector 1
        run_case(5'd1, 32'h0000_0001, 32'h9, 32'h9, 64'h100, 64'h104, 64'h0, 1'b1, rand_gr(), 1'b0);
        // directed: transfer-of-control with wide translation
        run_case(5'd31, 32'h0000_0007, 32'h0000_1234, 32'h0000_5678,
                 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0040, 64'h7000, 1'b0, rand_gr(), 1'b0);
        // directed: vector 0, vector 29 (just outside group)
        run_case(5'd0, 32'h0000_0005, 32'h1, 32'h2, 64'h8, 64'hC, 64'hABC0, 1'b0, rand_gr(), 1'b0);
        run_case(5'd29, 32'h0000_0003, 32'h1, 32'h2, 64'h8, 64'hC, 64'hABC0, 1'b1, rand_gr(), 1'b0);
        for (int i = 0; i < 40; i++) begin
            run_case(5'($urandom), $urandom, $urandom, $urandom, {$urandom, $urandom},
                     {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), rand_gr(),
                     1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule